// File: doc/BRIEF.md
# Supply Power-Up Sequencer

This block orders the switch-on of a power-management controller's supply rails after a cold start. When a start request is accepted it records a 2-bit startup-configuration code. It then holds every rail in its discharge state for a fixed settling interval. After that it raises the rail enables one time slot after another. Rails that share a slot are offset from each other by a few sub-steps, so their inrush currents do not add up.

While the sequence is running, the block reports busy and blocks the battery-side under-voltage fault so that the ramp cannot trip it. A one-cycle done pulse marks the end of the sequence. The power-gate driver enable is not part of the sequence: it only follows its software-written control bit.

All timing is counted in pulses of `tick_i`. Each pulse is one sub-step of 0.5 ms. Four sub-steps make one 2 ms slot, and sixteen make the 8 ms discharge interval.

Top module: `pwr_seq`

## Requirements
- R1: While the block is idle or finished, `start_i` sampled high at a clock edge is accepted. That edge captures `cfg_i` into `cfg_o` and sets `busy_o`.
- R2: From acceptance until the 16th tick, `dis_o` is 1 and `en_o` is all zeros. On the 16th tick `dis_o` falls.
- R3: Rail i has slot i/2 and sub-step offset 2*(i%2). Its position is p = 4*(i/2) + 2*(i%2), which gives 0,2,...,14 for rails 0..7. A selected rail's enable rises on tick 16+p after acceptance. Once risen, it stays high until the next accepted start.
- R4: The captured code selects the rails: 00 gives rails 0-3, 01 gives rails 0-5, 10 gives rails 0-7, and 11 gives every rail except 2 and 3. Rails that are not selected stay at 0.
- R5: On tick 32 after acceptance, `busy_o` falls and `done_o` is high for exactly one clock cycle. At that point every selected rail is enabled.
- R6: A `start_i` that arrives while `busy_o` is high is ignored. `cfg_o` and the tick timing stay unchanged.
- R7: `uv_o` equals `uv_i` while `busy_o` is low and is 0 while `busy_o` is high.
- R8: `pg_o` always equals `pg_sw_i`, in every sequencer state.
- R9: A start accepted after completion clears all enables on that edge and begins a new discharge interval.
- R10: After reset, `en_o` is 0, `dis_o` is 0, `busy_o` is 0, `done_o` is 0 and `cfg_o` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse per 0.5 ms sub-step |
| start_i | input | 1 | Cold-start request |
| cfg_i | input | 2 | Startup-configuration code |
| uv_i | input | 1 | Raw under-voltage fault |
| pg_sw_i | input | 1 | Software-written power-gate enable |
| en_o | output | 8 | Per-rail enables |
| dis_o | output | 1 | Hold rails in discharge |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle completion pulse |
| cfg_o | output | 2 | Captured configuration code |
| uv_o | output | 1 | Masked under-voltage fault |
| pg_o | output | 1 | Power-gate enable |

## Verification
Every registered result is due at the clock edge that samples the causing input: the accepting edge for a start, and the tick's own edge for discharge, enable and completion changes. The masked fault and the power-gate output are combinational from inputs and state. The driver puts the expected outputs for each tick into a queue before it raises the tick. The monitor waits for the edge on which that tick is high, then compares 1 ns later. Start acceptance, the end of the done pulse and the combinational outputs are checked 1 ns after the edge that produces them.

// File: rtl/pwr_seq.sv
module pwr_seq #(
  parameter int N_SUP      = 8,
  parameter int N_SLOT     = 4,
  parameter int SUB_SLOT   = 4,
  parameter int STAG       = 2,
  parameter int DISCH_SUBS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [1:0]       cfg_i,
  input  logic             uv_i,
  input  logic             pg_sw_i,
  output logic [N_SUP-1:0] en_o,
  output logic             dis_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       cfg_o,
  output logic             uv_o,
  output logic             pg_o
);
  localparam int STEPS = N_SLOT * SUB_SLOT;
  localparam int PER   = (N_SUP + N_SLOT - 1) / N_SLOT;
  localparam int CMAX  = (DISCH_SUBS > STEPS) ? DISCH_SUBS : STEPS;
  localparam int CW    = $clog2(CMAX + 1);
  localparam int QTR   = N_SUP / 4;
  localparam int BASE  = N_SUP - 2 * QTR;

  typedef enum logic [1:0] {S_IDLE, S_DIS, S_RAMP, S_ON} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [1:0]    code;
  logic          done_q;
  logic [N_SUP-1:0] sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      code   <= 2'b00;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE, S_ON: if (start_i) begin
          st   <= S_DIS;
          cnt  <= '0;
          code <= cfg_i;
        end
        S_DIS: if (tick_i) begin
          if (cnt == CW'(DISCH_SUBS - 1)) begin
            st  <= S_RAMP;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_RAMP: if (tick_i) begin
          if (cnt == CW'(STEPS - 1)) begin
            st     <= S_ON;
            done_q <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < N_SUP; i++) begin : g_rail
    localparam int  POS = (i / PER) * SUB_SLOT + (i % PER) * STAG;
    localparam logic K0 = (i < BASE);
    localparam logic K1 = (i < BASE + QTR);
    localparam logic K2 = (i < BASE + 2 * QTR);
    localparam logic K3 = ((i / PER) != 1);
    assign sel[i] = (code == 2'd0) ? K0 : (code == 2'd1) ? K1 :
                    (code == 2'd2) ? K2 : K3;
    if (POS == 0) begin : g_first
      assign en_o[i] = sel[i] & ((st == S_RAMP) | (st == S_ON));
    end else begin : g_later
      assign en_o[i] = sel[i] & ((st == S_ON) | ((st == S_RAMP) && (cnt >= CW'(POS))));
    end
  end

  assign busy_o = (st == S_DIS) | (st == S_RAMP);
  assign dis_o  = (st == S_DIS);
  assign done_o = done_q;
  assign cfg_o  = code;
  assign uv_o   = uv_i & ~busy_o;
  assign pg_o   = pg_sw_i;

  p_disch_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dis_o |-> (en_o == '0));
  p_en_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ((en_o & $past(en_o)) == $past(en_o)));
  p_done_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
  p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(cfg_o));
  p_uv_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !uv_o);
endmodule

// File: tb/pwr_seq_tb.sv
module pwr_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0, uv = 1'b1, pg = 1'b0;
  logic [1:0] cfg = 2'b00;
  logic [7:0] en;
  logic dis, busy, done, uvo, pgo;
  logic [1:0] cfgo;
  int checks = 0, fails = 0;

  typedef struct packed {logic [7:0] en; logic dis; logic busy; logic done;} exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  pwr_seq u_dut (.clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start), .cfg_i(cfg),
    .uv_i(uv), .pg_sw_i(pg), .en_o(en), .dis_o(dis), .busy_o(busy), .done_o(done),
    .cfg_o(cfgo), .uv_o(uvo), .pg_o(pgo));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] selm(input logic [1:0] c);
    case (c)
      2'd0: return 8'h0F;
      2'd1: return 8'h3F;
      2'd2: return 8'hFF;
      default: return 8'hF3;
    endcase
  endfunction

  function automatic logic [7:0] enm(input logic [1:0] c, input int j);
    logic [7:0] m = '0;
    for (int i = 0; i < 8; i++) if (4 * (i / 2) + 2 * (i % 2) <= j) m[i] = 1'b1;
    return m & selm(c);
  endfunction

  always begin
    @(posedge clk);
    if (tick) begin
      exp_t e;
      #1;
      e = q.pop_front();
      chk(en == e.en, "R3/R4 en_o", en, e.en);
      chk(dis == e.dis, "R2 dis_o", dis, e.dis);
      chk(busy == e.busy, "R5 busy_o", busy, e.busy);
      chk(done == e.done, "R5 done_o", done, e.done);
      chk(uvo == (uv & ~e.busy), "R7 uv_o", uvo, uv & ~e.busy);
    end
  end

  task automatic tick1(input exp_t e);
    q.push_back(e);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic run_seq(input logic [1:0] c, input bit mid_start);
    exp_t e;
    @(negedge clk) begin start = 1'b1; cfg = c; end
    @(posedge clk); #1;
    chk(busy == 1'b1, "R1 busy_o", busy, 1);
    chk(cfgo == c, "R1 cfg_o", cfgo, c);
    chk(en == 8'h00 && dis == 1'b1, "R9 en_o/dis_o", {dis, en}, 9'h100);
    @(negedge clk) begin start = 1'b0; cfg = ~c; end
    for (int k = 1; k <= 32; k++) begin
      if (mid_start && k == 6) begin
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(cfgo == c, "R6 cfg_o", cfgo, c);
      end
      if (k < 16) e = '{en: 8'h00, dis: 1'b1, busy: 1'b1, done: 1'b0};
      else if (k < 32) e = '{en: enm(c, k - 16), dis: 1'b0, busy: 1'b1, done: 1'b0};
      else e = '{en: selm(c), dis: 1'b0, busy: 1'b0, done: 1'b1};
      tick1(e);
    end
    @(posedge clk); #1;
    chk(done == 1'b0, "R5 done_o pulse end", done, 0);
    chk(en == selm(c), "R4 en_o held", en, selm(c));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk({en, dis, busy, done, cfgo} == '0, "R10 reset outputs", {en, dis, busy, done, cfgo}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(uvo == 1'b1, "R7 idle uv_o", uvo, 1);
    pg = 1'b1; #1;
    chk(pgo == 1'b1, "R8 pg_o idle", pgo, 1);
    run_seq(2'd0, 1'b0);
    pg = 1'b0; #1;
    chk(pgo == 1'b0, "R8 pg_o", pgo, 0);
    run_seq(2'd1, 1'b0);
    run_seq(2'd2, 1'b1);
    fork
      run_seq(2'd3, 1'b0);
      begin
        repeat (20) @(negedge clk);
        pg = 1'b1; #1;
        chk(pgo == 1'b1 && busy == 1'b1, "R8 pg_o busy", {busy, pgo}, 2'b11);
      end
    join
    uv = 1'b0;
    run_seq(2'd0, 1'b1);
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule